// File: doc/BRIEF.md
# I2C Master START Generator with Stuck-Bus Recovery

This block is the part of an I2C master that puts a START condition on the bus. It drives the enables of the open-drain SCL and SDA pads, reads both lines back, and acts on a start request, a bus-free flag from the bus monitor and a free-running clock-enable tick. A START is SDA pulled low while SCL stays high, held for one half-bit period. After the hold, SCL is also pulled low and both lines stay low. This hands the bus to the byte shifter until the request is withdrawn.

Another device may hold SDA low while the bus looks free, for example a slave that has lost bit sync. In that case the block does not issue the START. It clocks SCL with recovery pulses and checks SDA again after every second pulse. When SDA is released it issues a normal START and sets the status code 08h. The recovery needs no help from software. If SCL itself is held low, nothing can be done, so the block waits with SCL released. A request made while the bus is marked busy waits for the bus to become free. If neither line moves for a set number of ticks, the block forces the access.

States: ST_IDLE (lines released), ST_BUSY_WAIT (bus busy, watching for quiet), ST_PROBE (sample lines on a tick), ST_KICK_LO / ST_KICK_HI (low and high half of a recovery pulse), ST_START_HOLD (SDA low, SCL high), ST_HANDOFF (both low, status 08h). The transitions are:
- IDLE goes to PROBE when a request arrives and the bus is free, and to BUSY_WAIT when the bus is busy.
- BUSY_WAIT goes to PROBE when the bus becomes free or the quiet timeout expires. It goes back to IDLE if the request is dropped.
- On a tick with SCL high, PROBE goes to START_HOLD if SDA is high and to KICK_LO if SDA is low.
- KICK_LO goes to KICK_HI after a half period.
- KICK_HI goes back to KICK_LO after a half period of SCL high. After every second pulse it goes to PROBE instead.
- START_HOLD goes to HANDOFF after a half period.
- HANDOFF goes to IDLE when the request drops.

Top module: `i2c_start_gen`

## Requirements
- R1: While reset is held and right after it, both drive enables are 0, `start_done` is 0 and `status` reads F8h (no information).
- R2: With the bus free and SDA high, the block raises `sda_drv` while SCL is high. It keeps SCL released for exactly HALF_TICKS ticks, then drives both lines low. It pulses `start_done` for one clock and sets `status` to 08h.
- R3: If SDA reads low when sampled on a tick in PROBE, the block drives SCL low instead of starting. Each recovery pulse holds SCL low for exactly HALF_TICKS ticks.
- R4: The block samples SDA again after every RETRY_PULSES (default 2) recovery pulses. If SDA is released during the n-th pulse, the total number of pulses is n rounded up to a multiple of RETRY_PULSES (0 when SDA was never stuck).
- R5: While another device holds SCL low, the block never asserts `scl_drv` or `sda_drv`. It waits, and it completes the START once SCL is released.
- R6: After releasing SCL, the block does not assert `scl_drv` again while SCL still reads low (clock stretching). Only ticks with SCL high count toward a high half or the START hold.
- R7: A request made while `bus_free` is 0 waits while the lines move. After IDLE_TIMEOUT_TICKS consecutive ticks with no change on either line, the block forces a START. SDA goes low on the next tick after that.
- R8: If `bus_free` rises while a request is waiting, the block starts without waiting for the timeout.
- R9: Both lines stay driven low in HANDOFF until `start_req` drops, and then both are released. `status` holds 08h until the next request, which sets it back to F8h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Clock-enable tick that sets the bus timing |
| start_req | input | 1 | Request for a START; held until the handoff is done |
| bus_free | input | 1 | The bus monitor sees the bus as free |
| scl_in | input | 1 | Sampled SCL line level |
| sda_in | input | 1 | Sampled SDA line level |
| scl_drv | output | 1 | 1 pulls SCL low (open-drain enable) |
| sda_drv | output | 1 | 1 pulls SDA low (open-drain enable) |
| start_done | output | 1 | One-clock pulse when the START is complete |
| status | output | 8 | F8h when there is no information, 08h after a successful START |

## Verification
The checker covers the line-level rules on every cycle. SDA is pulled only after both lines read high. SCL is never pulled while another device holds it low. `start_done` lasts one clock and always comes with status 08h. Pulse counts, the half-period and hold lengths in ticks, and the forced-access delay depend on the whole scenario. Only the bench's scenarios can show these: they vary how long SDA stays stuck, stretch the clock, hold SCL low, and keep the bus busy with or without line activity.

// File: rtl/i2c_start_pkg.sv
package i2c_start_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_BUSY_WAIT,
        ST_PROBE,
        ST_KICK_LO,
        ST_KICK_HI,
        ST_START_HOLD,
        ST_HANDOFF
    } start_state_e;

    localparam logic [7:0] STAT_NO_INFO = 8'hF8;
    localparam logic [7:0] STAT_STARTED = 8'h08;

endpackage

// File: rtl/i2c_start_tick_cnt.sv
module i2c_start_tick_cnt #(
    parameter int LIMIT = 4,
    localparam int W = (LIMIT > 1) ? $clog2(LIMIT) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    output logic hit
);
    logic [W-1:0] cnt_q;

    assign hit = en && (cnt_q == W'(LIMIT - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (clr || hit)
            cnt_q <= '0;
        else if (en)
            cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/i2c_start_idle_watch.sv
module i2c_start_idle_watch #(
    parameter int TIMEOUT = 1000,
    localparam int W = (TIMEOUT > 1) ? $clog2(TIMEOUT) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic tick,
    input  logic scl_in,
    input  logic sda_in,
    output logic expired
);
    logic         scl_q, sda_q;
    logic         activity;
    logic [W-1:0] quiet_q;

    assign activity = (scl_in != scl_q) || (sda_in != sda_q);
    assign expired  = arm && tick && !activity && (quiet_q == W'(TIMEOUT - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q   <= 1'b1;
            sda_q   <= 1'b1;
            quiet_q <= '0;
        end else begin
            scl_q <= scl_in;
            sda_q <= sda_in;
            if (!arm || activity || expired)
                quiet_q <= '0;
            else if (tick)
                quiet_q <= quiet_q + 1'b1;
        end
    end
endmodule

// File: rtl/i2c_start_gen.sv
module i2c_start_gen
    import i2c_start_pkg::*;
#(
    parameter int HALF_TICKS         = 50,
    parameter int IDLE_TIMEOUT_TICKS = 1000,
    parameter int RETRY_PULSES       = 2,
    localparam int PW = (RETRY_PULSES > 1) ? $clog2(RETRY_PULSES) : 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       start_req,
    input  logic       bus_free,
    input  logic       scl_in,
    input  logic       sda_in,
    output logic       scl_drv,
    output logic       sda_drv,
    output logic       start_done,
    output logic [7:0] status
);
    start_state_e state_q, state_d;
    logic         half_en, half_hit, half_clr;
    logic         quiet_expired;
    logic [PW-1:0] kick_q;
    logic         last_kick;

    assign last_kick = (kick_q == PW'(RETRY_PULSES - 1));
    assign half_clr  = (state_d != state_q);

    always_comb begin
        unique case (state_q)
            ST_KICK_LO:                half_en = tick;
            ST_KICK_HI, ST_START_HOLD: half_en = tick && scl_in;
            default:                   half_en = 1'b0;
        endcase
    end

    i2c_start_tick_cnt #(.LIMIT(HALF_TICKS)) half_cnt_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (half_clr),
        .en    (half_en),
        .hit   (half_hit)
    );

    i2c_start_idle_watch #(.TIMEOUT(IDLE_TIMEOUT_TICKS)) idle_watch_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .arm     (state_q == ST_BUSY_WAIT),
        .tick    (tick),
        .scl_in  (scl_in),
        .sda_in  (sda_in),
        .expired (quiet_expired)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:
                if (start_req) state_d = bus_free ? ST_PROBE : ST_BUSY_WAIT;
            ST_BUSY_WAIT:
                if (!start_req)                     state_d = ST_IDLE;
                else if (bus_free || quiet_expired) state_d = ST_PROBE;
            ST_PROBE:
                if (tick && scl_in) state_d = sda_in ? ST_START_HOLD : ST_KICK_LO;
            ST_KICK_LO:
                if (half_hit) state_d = ST_KICK_HI;
            ST_KICK_HI:
                if (half_hit) state_d = last_kick ? ST_PROBE : ST_KICK_LO;
            ST_START_HOLD:
                if (half_hit) state_d = ST_HANDOFF;
            ST_HANDOFF:
                if (!start_req) state_d = ST_IDLE;
            default:
                state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            kick_q     <= '0;
            status     <= STAT_NO_INFO;
            start_done <= 1'b0;
        end else begin
            state_q    <= state_d;
            start_done <= (state_d == ST_HANDOFF) && (state_q != ST_HANDOFF);
            if (state_q == ST_IDLE)
                kick_q <= '0;
            else if (state_q == ST_KICK_HI && half_hit)
                kick_q <= last_kick ? '0 : kick_q + 1'b1;
            if (state_q == ST_IDLE && start_req)
                status <= STAT_NO_INFO;
            else if (state_d == ST_HANDOFF && state_q != ST_HANDOFF)
                status <= STAT_STARTED;
        end
    end

    always_comb begin
        scl_drv = 1'b0;
        sda_drv = 1'b0;
        unique case (state_q)
            ST_KICK_LO:    scl_drv = 1'b1;
            ST_START_HOLD: sda_drv = 1'b1;
            ST_HANDOFF: begin
                scl_drv = 1'b1;
                sda_drv = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/i2c_start_gen_chk.sv
module i2c_start_gen_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_in,
    input logic       sda_in,
    input logic       scl_drv,
    input logic       sda_drv,
    input logic       start_done,
    input logic [7:0] status
);
    // R2
    sda_pull_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_drv) |-> ($past(scl_in) && $past(sda_in)));

    // R5
    no_pull_on_held_scl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!scl_drv && !scl_in) |=> !scl_drv);

    // R6
    scl_pull_from_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_drv) |-> $past(scl_in));

    // R2
    done_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_done |-> (status == 8'h08));

    // R2
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_done |=> !start_done);
endmodule

bind i2c_start_gen i2c_start_gen_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_in     (scl_in),
    .sda_in     (sda_in),
    .scl_drv    (scl_drv),
    .sda_drv    (sda_drv),
    .start_done (start_done),
    .status     (status)
);

// File: tb/i2c_start_gen_tb_top.sv
module i2c_start_gen_tb_top;
    localparam int HALF     = 4;
    localparam int TIMEOUT  = 8;
    localparam int RETRY    = 2;
    localparam int TICK_DIV = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0;
    logic start_req = 1'b0;
    logic bus_free = 1'b1;
    logic scl_in, sda_in, scl_drv, sda_drv, start_done;
    logic [7:0] status;

    logic sda_stuck = 1'b0, scl_stuck = 1'b0, sda_wiggle = 1'b0, stretch_on = 1'b0;
    int   rel_n = 0;
    int   pulses = 0, lo_ticks = 0, hold_ticks = 0, stretch_drive = 0, stretch_cnt = 0;
    logic prev_scl_drv = 1'b0;
    int   div_cnt = 0;
    int   errors = 0, checks = 0;

    always #10 clk = ~clk;

    assign scl_in = ~(scl_drv | scl_stuck | (stretch_cnt != 0));
    assign sda_in = ~(sda_drv | (sda_stuck && (pulses < rel_n)) | sda_wiggle);

    i2c_start_gen #(.HALF_TICKS(HALF), .IDLE_TIMEOUT_TICKS(TIMEOUT), .RETRY_PULSES(RETRY)) dut_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .start_req(start_req), .bus_free(bus_free),
        .scl_in(scl_in), .sda_in(sda_in), .scl_drv(scl_drv), .sda_drv(sda_drv),
        .start_done(start_done), .status(status)
    );

    always @(posedge clk) begin
        div_cnt <= (div_cnt == TICK_DIV - 1) ? 0 : div_cnt + 1;
        tick    <= (div_cnt == TICK_DIV - 1);
    end

    always @(negedge clk) begin
        prev_scl_drv <= scl_drv;
        if (scl_drv && !prev_scl_drv && !sda_drv) pulses <= pulses + 1;
        if (tick && scl_drv && !sda_drv) lo_ticks <= lo_ticks + 1;
        if (tick && sda_drv && !scl_drv) hold_ticks <= hold_ticks + 1;
        if (stretch_cnt != 0 && scl_drv) stretch_drive <= stretch_drive + 1;
        if (prev_scl_drv && !scl_drv && stretch_on) stretch_cnt <= 7;
        else if (stretch_cnt > 0) stretch_cnt <= stretch_cnt - 1;
    end

    function automatic int exp_pulses(int n);
        return ((n + RETRY - 1) / RETRY) * RETRY;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_done(output bit ok);
        int guard = 0;
        while (!start_done && guard < 4000) begin
            @(negedge clk);
            guard++;
        end
        ok = start_done;
    endtask

    task automatic finish_handoff();
        @(negedge clk);
        chk(!start_done, "R2 done pulse width", start_done, 0);
        stretch_on = 1'b0;
        repeat (4) @(negedge clk);
        chk(scl_drv && sda_drv, "R9 handoff held", {scl_drv, sda_drv}, 3);
        start_req = 1'b0;
        sda_stuck = 1'b0;
        repeat (2) @(negedge clk);
        chk(!scl_drv && !sda_drv, "R9 release", {scl_drv, sda_drv}, 0);
        chk(status == 8'h08, "R9 status kept", status, 8'h08);
        repeat (6) @(negedge clk);
    endtask

    task automatic run_recovery(input int n, input bit stretch);
        int  bp, bl, bh, dp;
        bit  ok;
        @(negedge clk);
        bp = pulses; bl = lo_ticks; bh = hold_ticks;
        rel_n = pulses + n;
        sda_stuck = (n > 0);
        stretch_on = stretch;
        bus_free = 1'b1;
        start_req = 1'b1;
        @(negedge clk);
        chk(status == 8'hF8, "R9 status cleared", status, 8'hF8);
        wait_done(ok);
        chk(ok, "R2 start completes", ok, 1);
        chk(status == 8'h08, "R2 status", status, 8'h08);
        dp = pulses - bp;
        chk(dp == exp_pulses(n), "R4 pulse count", dp, exp_pulses(n));
        chk(lo_ticks - bl == dp * HALF, "R3 low half ticks", lo_ticks - bl, dp * HALF);
        chk(hold_ticks - bh == HALF, "R2 hold ticks", hold_ticks - bh, HALF);
        finish_handoff();
    endtask

    task automatic ticks_to_sda(output int t);
        int guard = 0;
        t = 0;
        while (!sda_drv && guard < 4000) begin
            if (tick) t++;
            @(negedge clk);
            guard++;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        bit ok;
        int t, bad;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        chk(!scl_drv && !sda_drv && !start_done, "R1 outputs in reset", {scl_drv, sda_drv, start_done}, 0);
        chk(status == 8'hF8, "R1 status in reset", status, 8'hF8);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(!scl_drv && !sda_drv && status == 8'hF8, "R1 after reset", status, 8'hF8);

        // R2 and R3/R4 directed corners
        run_recovery(0, 1'b0);
        run_recovery(1, 1'b0);
        run_recovery(2, 1'b0);
        run_recovery(5, 1'b0);
        // R6 stretching during recovery
        run_recovery(3, 1'b1);
        chk(stretch_drive == 0, "R6 no pull while stretched", stretch_drive, 0);

        // random mix of stuck lengths and stretching
        for (int i = 0; i < 10; i++) begin
            run_recovery(int'($urandom_range(0, 6)), 1'($urandom_range(0, 1)));
        end
        chk(stretch_drive == 0, "R6 random stretch", stretch_drive, 0);

        // R5 SCL held low by another device
        @(negedge clk);
        scl_stuck = 1'b1;
        sda_stuck = 1'b0;
        bus_free = 1'b1;
        start_req = 1'b1;
        bad = 0;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (scl_drv || sda_drv || start_done) bad++;
        end
        chk(bad == 0, "R5 wait on held SCL", bad, 0);
        scl_stuck = 1'b0;
        wait_done(ok);
        chk(ok, "R5 completes after release", ok, 1);
        finish_handoff();

        // R7 quiet busy bus -> forced access
        @(negedge clk);
        bus_free = 1'b0;
        start_req = 1'b1;
        @(negedge clk);
        ticks_to_sda(t);
        chk(t == TIMEOUT + 1, "R7 forced access ticks", t, TIMEOUT + 1);
        wait_done(ok);
        chk(ok, "R7 forced start done", ok, 1);
        finish_handoff();

        // R7 activity keeps the block waiting
        @(negedge clk);
        bus_free = 1'b0;
        start_req = 1'b1;
        bad = 0;
        for (int i = 0; i < 60; i++) begin
            if (i % 6 == 0) sda_wiggle = ~sda_wiggle;
            @(negedge clk);
            if (scl_drv || sda_drv) bad++;
        end
        sda_wiggle = 1'b0;
        chk(bad == 0, "R7 no start while bus active", bad, 0);
        wait_done(ok);
        chk(ok, "R7 start after quiet", ok, 1);
        finish_handoff();

        // R8 bus becomes free while waiting
        @(negedge clk);
        bus_free = 1'b0;
        start_req = 1'b1;
        @(negedge clk);
        t = 0;
        for (int i = 0; i < 7; i++) begin
            if (tick) t++;
            @(negedge clk);
        end
        bus_free = 1'b1;
        begin
            int t2;
            ticks_to_sda(t2);
            t = t + t2;
        end
        chk(t < TIMEOUT, "R8 early start on free bus", t, TIMEOUT);
        wait_done(ok);
        chk(ok, "R8 start done", ok, 1);
        finish_handoff();

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule